// File: doc/BRIEF.md
# Event Histogram Binning Controller

This block turns a stream of 48-bit event packets into a two-dimensional count table. One axis is time and the other is energy. Each packet carries a timestamp field and an energy field. A small slice of the timestamp selects one of 16 temporal bins. The energy, after subtracting a programmable floor and shifting right by a programmable amount, selects one of 64 spectral bins. The count in the selected cell is then incremented by a two-step read-modify-write on an internal memory. Events whose energy lies outside a programmable window are consumed from the input but leave every count unchanged.

The table is double-buffered. One bank accumulates while the other holds a frozen copy that a host reads one cell at a time over a simple register bus. The host asks for a swap by writing a control register. The block then stops taking packets, lets any increment still in the pipeline finish, and exchanges the roles of the banks. It then zeroes every cell of the bank that has just become the accumulating one before it accepts input again. The same zeroing pass runs on the accumulating bank after reset.

Top module: `evt_hist_binner`

## Requirements
- R1: After reset, bank 0 accumulates, the energy floor reads 0, the energy ceiling reads 0xFFFF and the shift reads 0. `evt_ready` stays low for exactly 1024 cycles, counted from the first cycle out of reset, while bank 0 is zeroed.
- R2: A packet taken by the handshake (`evt_valid` and `evt_ready` high at a clock edge) with energy in the window adds one to the cell at index t*64+s. Here t is packet bits 35:32 and s is (energy − floor) >> shift, the energy being packet bits 15:0. Once that bank is made the readout bank, the cell reads back at register address 0x400+index.
- R3: A packet whose energy is below the floor or above the ceiling changes no count. Energies equal to the floor or to the ceiling are counted.
- R4: When (energy − floor) >> shift exceeds 63, the event is counted in spectral bin 63.
- R5: Packets to the same cell on consecutive or alternating cycles are all counted, with none lost.
- R6: A count stops at 0xFFFF and does not wrap to zero.
- R7: Writing 1 to bit 0 of register 3 requests a swap. Intake stops, and increments still in the pipeline complete. The active bank then toggles and the new active bank is zeroed, with `evt_ready` held low for at least 1024 cycles. A read of register 3 returns the active bank number in bit 0.
- R8: Packet bits 47:36 and 31:16 have no effect on which cell is counted.
- R9: Register addresses with bit 10 clear select a control register by bits 1:0. These are 0 for the energy floor, 1 for the energy ceiling, 2 for the shift (bits 3:0) and 3 for control. Written values read back. Read data appears on `reg_rdata` after the clock edge that samples `reg_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| evt_valid | input | 1 | Packet offered |
| evt_ready | output | 1 | Block can take a packet this cycle |
| evt_data | input | 48 | Event packet |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 11 | Register or histogram cell address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, registered |

## Verification
The per-cycle properties cover the sequencing rules. Intake is closed during zeroing. A bank toggle follows a drained pipeline and starts the zeroing pass. An out-of-window packet never enters the increment pipeline, and an in-window one always does. No increment writes a zero. The counts themselves can only be shown by the bench scenarios, which compare read-back cells against a behavioural model of both banks. These scenarios cover floor and ceiling boundaries, clamping into the top spectral bin, back-to-back and interleaved hits on one cell, ignored packet bits, saturation after 65537 hits, and the zeroing of a recycled bank.

// File: rtl/ehb_pkg.sv
package ehb_pkg;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_DRAIN,
    ST_CLEAR
  } ehb_state_t;

  localparam logic [1:0] SEL_FLOOR = 2'd0;
  localparam logic [1:0] SEL_CEIL  = 2'd1;
  localparam logic [1:0] SEL_SHIFT = 2'd2;
  localparam logic [1:0] SEL_CTRL  = 2'd3;

endpackage

// File: rtl/ehb_intake.sv
module ehb_intake #(
  parameter int TBIN_W = 4,
  parameter int EBIN_W = 6,
  parameter int E_W    = 16,
  parameter int SH_W   = 4
) (
  input  logic [TBIN_W-1:0]        tfield,
  input  logic [E_W-1:0]           energy,
  input  logic [E_W-1:0]           floor_lim,
  input  logic [E_W-1:0]           ceil_lim,
  input  logic [SH_W-1:0]          shift,
  output logic                     in_win,
  output logic [TBIN_W+EBIN_W-1:0] bin_idx
);

  localparam logic [E_W-1:0] EBIN_TOP = E_W'((1 << EBIN_W) - 1);

  logic [E_W-1:0]    scaled;
  logic [EBIN_W-1:0] ebin;

  always_comb begin
    in_win = (energy >= floor_lim) && (energy <= ceil_lim);
    scaled = (energy - floor_lim) >> shift;
    if (scaled > EBIN_TOP) begin
      ebin = '1;
    end else begin
      ebin = scaled[EBIN_W-1:0];
    end
    bin_idx = {tfield, ebin};
  end

endmodule

// File: rtl/ehb_incr.sv
module ehb_incr #(
  parameter int BIN_W = 10,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [BIN_W-1:0] take_idx,
  input  logic [CNT_W-1:0] rd_cnt,
  output logic [BIN_W-1:0] rd_idx,
  output logic             s1_valid,
  output logic             s2_valid,
  output logic             we,
  output logic [BIN_W-1:0] w_idx,
  output logic [CNT_W-1:0] w_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             s1_v_q, s1_v_d;
  logic             s2_v_q, s2_v_d;
  logic [BIN_W-1:0] s1_idx_q, s1_idx_d;
  logic [BIN_W-1:0] s2_idx_q, s2_idx_d;
  logic [CNT_W-1:0] s2_cnt_q, s2_cnt_d;
  logic             s1_en;
  logic             fwd;

  // increment with saturation on the write side
  always_comb begin
    if (s2_cnt_q == CNT_MAX) begin
      w_cnt = CNT_MAX;
    end else begin
      w_cnt = s2_cnt_q + CNT_W'(1);
    end
  end

  always_comb begin
    s1_en    = s1_v_q;
    fwd      = s2_v_q && (s2_idx_q == s1_idx_q);
    s1_v_d   = take;
    s1_idx_d = take ? take_idx : s1_idx_q;
    s2_v_d   = s1_v_q;
    s2_idx_d = s1_idx_q;
    s2_cnt_d = fwd ? w_cnt : rd_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v_q   <= 1'b0;
      s2_v_q   <= 1'b0;
      s1_idx_q <= '0;
      s2_idx_q <= '0;
      s2_cnt_q <= '0;
    end else begin
      s1_v_q   <= s1_v_d;
      s2_v_q   <= s2_v_d;
      s1_idx_q <= s1_idx_d;
      if (s1_en) begin
        s2_idx_q <= s2_idx_d;
        s2_cnt_q <= s2_cnt_d;
      end
    end
  end

  assign rd_idx   = s1_idx_q;
  assign s1_valid = s1_v_q;
  assign s2_valid = s2_v_q;
  assign we       = s2_v_q;
  assign w_idx    = s2_idx_q;

endmodule

// File: rtl/ehb_banks.sv
module ehb_banks #(
  parameter int BIN_W = 10,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             we,
  input  logic             w_bank,
  input  logic [BIN_W-1:0] w_idx,
  input  logic [CNT_W-1:0] w_cnt,
  input  logic             a_bank,
  input  logic [BIN_W-1:0] a_idx,
  output logic [CNT_W-1:0] a_cnt,
  input  logic             b_bank,
  input  logic [BIN_W-1:0] b_idx,
  output logic [CNT_W-1:0] b_cnt
);

  localparam int DEPTH = 1 << BIN_W;

  logic [CNT_W-1:0] a_rd [2];
  logic [CNT_W-1:0] b_rd [2];

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [CNT_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && (w_bank == 1'(g))) begin
        mem[w_idx] <= w_cnt;
      end
    end

    assign a_rd[g] = mem[a_idx];
    assign b_rd[g] = mem[b_idx];
  end

  assign a_cnt = a_rd[a_bank];
  assign b_cnt = b_rd[b_bank];

endmodule

// File: rtl/ehb_ctrl.sv
module ehb_ctrl
  import ehb_pkg::*;
#(
  parameter int BIN_W = 10,
  parameter int CNT_W = 16,
  parameter int E_W   = 16,
  parameter int SH_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_re,
  input  logic             is_hist,
  input  logic [1:0]       reg_sel,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic [CNT_W-1:0] hist_cnt,
  input  logic             pipe_busy,
  output logic [E_W-1:0]   floor_lim,
  output logic [E_W-1:0]   ceil_lim,
  output logic [SH_W-1:0]  shift,
  output logic             act_bank,
  output logic             clearing,
  output logic [BIN_W-1:0] clr_idx,
  output logic             intake_open
);

  ehb_state_t       state_q, state_d;
  logic             act_q, act_d;
  logic             pend_q, pend_d;
  logic [BIN_W-1:0] clr_q, clr_d;
  logic [E_W-1:0]   floor_q, ceil_q;
  logic [SH_W-1:0]  sh_q;
  logic [CNT_W-1:0] rdata_q, rdata_d;
  logic             floor_en, ceil_en, sh_en, swap_wr, pend_drop;
  logic [CNT_W-1:0] reg_mux;

  always_comb begin
    floor_en = reg_we && !is_hist && (reg_sel == SEL_FLOOR);
    ceil_en  = reg_we && !is_hist && (reg_sel == SEL_CEIL);
    sh_en    = reg_we && !is_hist && (reg_sel == SEL_SHIFT);
    swap_wr  = reg_we && !is_hist && (reg_sel == SEL_CTRL) && reg_wdata[0];
  end

  // swap sequencing: run -> drain -> clear -> run
  always_comb begin
    state_d   = state_q;
    act_d     = act_q;
    clr_d     = clr_q;
    pend_drop = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (pend_q) state_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (!pipe_busy) begin
          state_d   = ST_CLEAR;
          act_d     = ~act_q;
          clr_d     = '0;
          pend_drop = 1'b1;
        end
      end
      ST_CLEAR: begin
        clr_d = clr_q + BIN_W'(1);
        if (clr_q == '1) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
    pend_d = pend_drop ? 1'b0 : pend_q;
    if (swap_wr) pend_d = 1'b1;
  end

  always_comb begin
    case (reg_sel)
      SEL_FLOOR: reg_mux = CNT_W'(floor_q);
      SEL_CEIL:  reg_mux = CNT_W'(ceil_q);
      SEL_SHIFT: reg_mux = CNT_W'(sh_q);
      default:   reg_mux = CNT_W'(act_q);
    endcase
    rdata_d = is_hist ? hist_cnt : reg_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CLEAR;
      act_q   <= 1'b0;
      pend_q  <= 1'b0;
      clr_q   <= '0;
    end else begin
      state_q <= state_d;
      act_q   <= act_d;
      pend_q  <= pend_d;
      clr_q   <= clr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      floor_q <= '0;
      ceil_q  <= '1;
      sh_q    <= '0;
      rdata_q <= '0;
    end else begin
      if (floor_en) floor_q <= reg_wdata[E_W-1:0];
      if (ceil_en)  ceil_q  <= reg_wdata[E_W-1:0];
      if (sh_en)    sh_q    <= reg_wdata[SH_W-1:0];
      if (reg_re)   rdata_q <= rdata_d;
    end
  end

  assign reg_rdata   = rdata_q;
  assign floor_lim   = floor_q;
  assign ceil_lim    = ceil_q;
  assign shift       = sh_q;
  assign act_bank    = act_q;
  assign clearing    = (state_q == ST_CLEAR);
  assign clr_idx     = clr_q;
  assign intake_open = (state_q == ST_RUN) && !pend_q;

endmodule

// File: rtl/evt_hist_binner.sv
module evt_hist_binner #(
  parameter int PKT_W    = 48,
  parameter int TIME_LSB = 32,
  parameter int TBIN_W   = 4,
  parameter int EBIN_W   = 6,
  parameter int E_W      = 16,
  parameter int CNT_W    = 16,
  parameter int SH_W     = 4,
  parameter int ADDR_W   = TBIN_W + EBIN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [PKT_W-1:0]  evt_data,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata
);

  localparam int BIN_W = TBIN_W + EBIN_W;

  logic [E_W-1:0]   lim_lo, lim_hi;
  logic [SH_W-1:0]  shift;
  logic             in_win, take;
  logic [BIN_W-1:0] take_idx, inc_rd_idx, inc_idx, clr_idx;
  logic [CNT_W-1:0] inc_rd_cnt, inc_cnt, out_cnt;
  logic             inc_we, s1_valid, s2_valid;
  logic             act_bank, clearing, intake_open;
  logic             mem_we;
  logic [BIN_W-1:0] mem_idx;
  logic [CNT_W-1:0] mem_cnt;
  logic             unused_fields;

  assign unused_fields = ^{evt_data[PKT_W-1:TIME_LSB+TBIN_W],
                           evt_data[TIME_LSB-1:E_W],
                           reg_addr[ADDR_W-2:BIN_W]};

  ehb_intake #(
    .TBIN_W(TBIN_W), .EBIN_W(EBIN_W), .E_W(E_W), .SH_W(SH_W)
  ) u_intake (
    .tfield    (evt_data[TIME_LSB +: TBIN_W]),
    .energy    (evt_data[E_W-1:0]),
    .floor_lim (lim_lo),
    .ceil_lim  (lim_hi),
    .shift     (shift),
    .in_win    (in_win),
    .bin_idx   (take_idx)
  );

  assign evt_ready = intake_open;
  assign take      = evt_valid && evt_ready && in_win;

  ehb_incr #(.BIN_W(BIN_W), .CNT_W(CNT_W)) u_incr (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .take_idx (take_idx),
    .rd_cnt   (inc_rd_cnt),
    .rd_idx   (inc_rd_idx),
    .s1_valid (s1_valid),
    .s2_valid (s2_valid),
    .we       (inc_we),
    .w_idx    (inc_idx),
    .w_cnt    (inc_cnt)
  );

  // zeroing pass owns the write port; it only runs with the pipeline empty
  always_comb begin
    if (clearing) begin
      mem_we  = 1'b1;
      mem_idx = clr_idx;
      mem_cnt = '0;
    end else begin
      mem_we  = inc_we;
      mem_idx = inc_idx;
      mem_cnt = inc_cnt;
    end
  end

  ehb_banks #(.BIN_W(BIN_W), .CNT_W(CNT_W)) u_banks (
    .clk    (clk),
    .we     (mem_we),
    .w_bank (act_bank),
    .w_idx  (mem_idx),
    .w_cnt  (mem_cnt),
    .a_bank (act_bank),
    .a_idx  (inc_rd_idx),
    .a_cnt  (inc_rd_cnt),
    .b_bank (~act_bank),
    .b_idx  (reg_addr[BIN_W-1:0]),
    .b_cnt  (out_cnt)
  );

  ehb_ctrl #(
    .BIN_W(BIN_W), .CNT_W(CNT_W), .E_W(E_W), .SH_W(SH_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_re      (reg_re),
    .is_hist     (reg_addr[ADDR_W-1]),
    .reg_sel     (reg_addr[1:0]),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .hist_cnt    (out_cnt),
    .pipe_busy   (s1_valid || s2_valid),
    .floor_lim   (lim_lo),
    .ceil_lim    (lim_hi),
    .shift       (shift),
    .act_bank    (act_bank),
    .clearing    (clearing),
    .clr_idx     (clr_idx),
    .intake_open (intake_open)
  );

endmodule

// File: rtl/ehb_chk.sv
module ehb_chk #(
  parameter int E_W   = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_valid,
  input logic             evt_ready,
  input logic [E_W-1:0]   energy,
  input logic [E_W-1:0]   lim_lo,
  input logic [E_W-1:0]   lim_hi,
  input logic             s1_valid,
  input logic             s2_valid,
  input logic             clearing,
  input logic             act_bank,
  input logic             inc_we,
  input logic [CNT_W-1:0] inc_cnt
);

  AST_NO_INTAKE_WHILE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clearing |-> !evt_ready); // R7

  AST_TOGGLE_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (act_bank != $past(act_bank)) |-> (!$past(s1_valid) && !$past(s2_valid))); // R7

  AST_TOGGLE_STARTS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (act_bank != $past(act_bank)) |-> clearing); // R7

  AST_OUT_OF_WINDOW_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ready && ((energy < lim_lo) || (energy > lim_hi))) |=> !s1_valid); // R3

  AST_IN_WINDOW_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ready && (energy >= lim_lo) && (energy <= lim_hi)) |=> s1_valid); // R2

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    inc_we |-> (inc_cnt != '0)); // R6

endmodule

bind evt_hist_binner ehb_chk #(.E_W(E_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_valid (evt_valid),
  .evt_ready (evt_ready),
  .energy    (evt_data[E_W-1:0]),
  .lim_lo    (lim_lo),
  .lim_hi    (lim_hi),
  .s1_valid  (s1_valid),
  .s2_valid  (s2_valid),
  .clearing  (clearing),
  .act_bank  (act_bank),
  .inc_we    (inc_we),
  .inc_cnt   (inc_cnt)
);

// File: tb/sim_evt_hist_binner.sv
module sim_evt_hist_binner;

  localparam int CLK_PERIOD = 10;
  localparam int NB         = 1024;
  localparam int HIST       = 'h400;

  logic        clk;
  logic        rst_n;
  logic        evt_valid;
  logic        evt_ready;
  logic [47:0] evt_data;
  logic        reg_we;
  logic        reg_re;
  logic [10:0] reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;

  int m_bank [2][NB];
  int m_act, m_lo, m_hi, m_sh;
  int checks, fails;

  evt_hist_binner u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_ready (evt_ready),
    .evt_data  (evt_data),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  // model: clears the new active bank on a swap request
  task automatic reg_write(input int addr, input int data);
    reg_we    = 1'b1;
    reg_addr  = 11'(addr);
    reg_wdata = 16'(data);
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
    case (addr)
      0: m_lo = data & 'hFFFF;
      1: m_hi = data & 'hFFFF;
      2: m_sh = data & 'hF;
      3: if ((data & 1) != 0) begin
           m_act ^= 1;
           for (int i = 0; i < NB; i++) m_bank[m_act][i] = 0;
         end
      default: ;
    endcase
  endtask

  task automatic reg_read(input int addr, output int v);
    reg_re   = 1'b1;
    reg_addr = 11'(addr);
    @(posedge clk);
    @(negedge clk);
    reg_re = 1'b0;
    v = int'(reg_rdata);
  endtask

  task automatic wait_ready(output int lows);
    lows = 0;
    while (!evt_ready) begin
      lows++;
      @(negedge clk);
    end
  endtask

  task automatic send(input int t, input int e, input int junk);
    int sc;
    evt_valid = 1'b1;
    evt_data  = {12'(junk * 3 + 5), 4'(t), 16'(junk * 7), 16'(e)};
    while (!evt_ready) @(negedge clk);
    @(posedge clk);
    if (e >= m_lo && e <= m_hi) begin
      sc = (e - m_lo) >> m_sh;
      if (sc > 63) sc = 63;
      if (m_bank[m_act][t * 64 + sc] < 65535) m_bank[m_act][t * 64 + sc]++;
    end
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic swap(input int exp_act);
    int lows, v;
    reg_write(3, 1);
    wait_ready(lows);
    chk(lows >= NB, "R7 intake held during zeroing", lows, NB);
    reg_read(3, v);
    chk((v & 1) == exp_act, "R7 active bank status", v & 1, exp_act);
  endtask

  task automatic check_cell(input int t, input int s, input string tag);
    int v;
    reg_read(HIST + t * 64 + s, v);
    chk(v == m_bank[m_act ^ 1][t * 64 + s], tag, v, m_bank[m_act ^ 1][t * 64 + s]);
  endtask

  task automatic check_all(input string tag);
    int v, bad, first_act, first_exp;
    bad = 0;
    first_act = 0;
    first_exp = 0;
    for (int i = 0; i < NB; i++) begin
      reg_read(HIST + i, v);
      if (v != m_bank[m_act ^ 1][i]) begin
        if (bad == 0) begin
          first_act = v;
          first_exp = m_bank[m_act ^ 1][i];
        end
        bad++;
      end
    end
    chk(bad == 0, tag, first_act, first_exp);
  endtask

  initial begin
    int lows, v;
    checks = 0;
    fails  = 0;
    m_act  = 0;
    m_lo   = 0;
    m_hi   = 'hFFFF;
    m_sh   = 0;
    for (int i = 0; i < NB; i++) m_bank[0][i] = 0;
    rst_n = 1'b0;
    evt_valid = 1'b0;
    evt_data  = '0;
    reg_we = 1'b0;
    reg_re = 1'b0;
    reg_addr = '0;
    reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset zeroing pass and reset values
    wait_ready(lows);
    chk(lows == NB, "R1 reset zeroing length", lows, NB);
    reg_read(3, v);
    chk(v == 0, "R1 active bank after reset", v, 0);
    reg_read(0, v);
    chk(v == 0, "R1 floor reset", v, 0);
    reg_read(1, v);
    chk(v == 'hFFFF, "R1 ceiling reset", v, 'hFFFF);
    reg_read(2, v);
    chk(v == 0, "R1 shift reset", v, 0);

    // R9: limit registers read back
    reg_write(0, 100);
    reg_write(1, 1000);
    reg_write(2, 2);
    reg_read(0, v);
    chk(v == 100, "R9 floor readback", v, 100);
    reg_read(1, v);
    chk(v == 1000, "R9 ceiling readback", v, 1000);
    reg_read(2, v);
    chk(v == 2, "R9 shift readback", v, 2);

    // phase 1: window, clamp, back-to-back, ignored bits
    send(1, 99, 0);
    send(1, 100, 1);
    send(2, 1000, 2);
    send(2, 1001, 3);
    send(3, 50, 4);
    send(4, 104, 5);
    send(4, 355, 6);
    send(5, 359, 7);
    send(6, 351, 8);
    for (int i = 0; i < 6; i++) send(7, 120, 9);
    send(8, 121, 100);
    send(8, 121, 2000);
    send(8, 121, 4095);
    swap(1);
    check_all("R2 full bank after phase 1");
    check_cell(1, 0, "R3 floor energy counted once");
    check_cell(2, 63, "R3 ceiling counted, above ceiling dropped");
    check_cell(4, 1, "R2 shifted spectral bin");
    check_cell(4, 63, "R4 scaled value 63 stays in top bin");
    check_cell(5, 63, "R4 scaled value 64 clamps to top bin");
    check_cell(6, 62, "R2 bin 62");
    check_cell(7, 5, "R5 back-to-back hits");
    check_cell(8, 5, "R8 ignored bits map to one cell");

    // phase 2: interleaved hits, shift 0, bank 1 zeroed at the first swap
    reg_write(2, 0);
    send(0, 110, 1);
    send(15, 163, 2);
    for (int i = 0; i < 4; i++) begin
      send(9, 120, i);
      send(9, 121, i);
    end
    swap(0);
    check_all("R7 bank 1 holds only phase 2");
    check_cell(9, 20, "R5 interleaved hits cell A");
    check_cell(9, 21, "R5 interleaved hits cell B");

    // phase 3: bank 0 recycled and zeroed
    send(3, 200, 1);
    send(3, 200, 2);
    swap(1);
    check_all("R7 recycled bank zeroed before reuse");

    // phase 4: saturation
    reg_write(0, 0);
    reg_write(1, 'hFFFF);
    for (int i = 0; i < 65537; i++) send(3, 5, i);
    swap(0);
    reg_read(HIST + 3 * 64 + 5, v);
    chk(v == 'hFFFF, "R6 count saturates", v, 'hFFFF);
    check_cell(3, 4, "R6 neighbour untouched");

    finish_run();
  end

endmodule